// File: doc/BRIEF.md
# Presentation Timestamp Generator

This block produces the 16-bit presentation timestamp carried by each outgoing isochronous audio packet. Time is counted in ticks of a 24.576 MHz bus clock: one bus cycle is 3072 ticks and there are 8000 cycles per second. Each time the packet scheduler strobes a new bus cycle, the block moves a running tick offset forward by a step that depends on the sample rate. It then turns the offset, plus a fixed transfer delay, into a timestamp. If no sample event falls into that cycle, it returns the "no information" code 0xFFFF instead.

The sample rates fall into two families. The 32/48/96/192 kHz rates use a constant step. The 44.1/88.2/176.4 kHz rates step by 1386 or 1387 ticks, following a fixed 147-entry phase pattern; this keeps the long-run rate exact and locked to the bus clock. The transfer delay depends on the rate and on whether blocking transmission is used. A start pulse re-arms the sequence before a stream begins.

Top module: `syt_gen`

## Requirements
- R1: After reset or a `start` pulse, the stored offset is 3072 and the fractional phase is 67. So the first cycle strobe gives offset 0 and a timestamp that reflects the transfer delay alone.
- R2: On each strobe, a stored offset of 3072 or more is reduced by 3072 with no step added. When the new offset is 3072 or more, `syt_out` is 0xFFFF and `syt_none` is 1.
- R3: `rate` codes are 0=32 kHz, 1=44.1, 2=48, 3=88.2, 4=96, 5=176.4, 6=192 kHz (7 behaves as 6). For codes 0, 2, 4 and 6 the step is 3072 ticks at code 0 and 1024 ticks otherwise. At 32 kHz, timestamps and 0xFFFF therefore alternate.
- R4: For codes 1, 3 and 5 the step is 1386, plus 1 when k = phase mod 13 is non-zero and a multiple of 4, or when phase is 146. The phase advances only on strobes that add a step, and wraps from 146 to 0.
- R5: With `blocking` low the transfer delay is 8704 ticks for every rate.
- R6: With `blocking` high the transfer delay is 14848 ticks at code 0, 13162 ticks for codes 1/3/5, and 12800 ticks for codes 2/4/6/7.
- R7: For a new offset below 3072, let D = offset + delay and C = the adjusted cycle. Then `syt_out` = ((C + D div 3072) × 4096 + D mod 3072) mod 65536, `syt_none` = 0, and bits 11:0 are below 3072.
- R8: The adjusted cycle is `cycle_in[15:13]` × 8000 + `cycle_in[12:0]` + 48, taken modulo 64000.
- R9: Outputs change only on the clock edge that samples `cyc_strobe` high. `syt_valid` is high for exactly the one cycle after that edge, and the outputs hold their values otherwise. After reset `syt_valid` is 0 and `syt_out` is 0xFFFF.
- R10: When `start` and `cyc_strobe` are both high, the re-arm wins: no timestamp is produced and `syt_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Re-arm offset and phase before a stream |
| cyc_strobe | input | 1 | One pulse per bus cycle to be stamped |
| cycle_in | input | 16 | Bus cycle count: seconds in 15:13, cycle in 12:0 |
| rate | input | 3 | Sample-rate code |
| blocking | input | 1 | Blocking transmission mode select |
| syt_out | output | 16 | Timestamp or 0xFFFF |
| syt_none | output | 1 | No sample event in this cycle |
| syt_valid | output | 1 | Outputs updated on the last edge |

## Verification
The offset register and the 44.1 kHz phase are hidden state, and a wrong value in either reaches the ports at the next strobe. A bad offset moves the low twelve bits of the timestamp, or turns a stamp into 0xFFFF, on the very next output. A phase that is off by one may stay invisible until the pattern reaches its next 1387-tick step, which comes within at most thirteen stamps. Long comparisons at each fractional rate therefore matter more than single-step checks. The cycle adjustment only appears in bits 15:12, so the wrap near second 7 must be checked directly.

// File: rtl/syt_pkg.sv
package syt_pkg;

    localparam int TICKS_PER_CYC   = 3072;
    localparam int CYCS_PER_SEC    = 8000;
    localparam int SEC_SPAN        = 8;
    localparam int CYC_WRAP        = CYCS_PER_SEC * SEC_SPAN;
    localparam int QUEUE_AHEAD     = 48;
    localparam int DELAY_BASE      = 16'h2E00 - TICKS_PER_CYC;
    localparam int FRAC_STEP       = 1386;
    localparam int FRAC_PHASES     = 147;
    localparam int FRAC_GROUP      = 13;
    localparam int FRAC_PHASE_INIT = 67;
    localparam int OFF_W           = 16;

    typedef enum logic [2:0] {
        RC_32K   = 3'd0,
        RC_44K1  = 3'd1,
        RC_48K   = 3'd2,
        RC_88K2  = 3'd3,
        RC_96K   = 3'd4,
        RC_176K4 = 3'd5,
        RC_192K  = 3'd6,
        RC_ALT   = 3'd7
    } rate_e;

    typedef struct packed {
        logic [OFF_W-1:0] step;
        logic [OFF_W-1:0] delay;
        logic             frac;
    } rate_cfg_t;

    function automatic logic is_frac(rate_e r);
        return (r == RC_44K1) || (r == RC_88K2) || (r == RC_176K4);
    endfunction

    function automatic longint rate_hz(rate_e r);
        case (r)
            RC_32K:   return 32000;
            RC_44K1:  return 44100;
            RC_48K:   return 48000;
            RC_88K2:  return 88200;
            RC_96K:   return 96000;
            RC_176K4: return 176400;
            default:  return 192000;
        endcase
    endfunction

    function automatic longint events_per_pkt(rate_e r);
        case (r)
            RC_32K, RC_44K1, RC_48K: return 8;
            RC_88K2, RC_96K:         return 16;
            default:                 return 32;
        endcase
    endfunction

    function automatic rate_cfg_t rate_cfg(rate_e r, logic blk);
        rate_cfg_t c;
        longint    extra;
        extra   = (longint'(TICKS_PER_CYC) * CYCS_PER_SEC * events_per_pkt(r)) / rate_hz(r);
        c.frac  = is_frac(r);
        c.step  = (r == RC_32K) ? OFF_W'(TICKS_PER_CYC) : OFF_W'(1024);
        c.delay = blk ? OFF_W'(longint'(DELAY_BASE) + extra) : OFF_W'(DELAY_BASE);
        return c;
    endfunction

endpackage

// File: rtl/syt_phase_seq.sv
module syt_phase_seq
    import syt_pkg::*;
#(
    parameter int PHASES = FRAC_PHASES,
    parameter int GROUP  = FRAC_GROUP,
    parameter int INIT   = FRAC_PHASE_INIT
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic advance,
    output logic extra
);
    localparam int PW       = $clog2(PHASES);
    localparam int GW       = $clog2(GROUP);
    localparam int INIT_IDX = INIT % GROUP;

    logic [PW-1:0] phase;
    logic [GW-1:0] idx;

    // idx tracks phase mod GROUP without a divider
    assign extra = ((idx != '0) && (idx[1:0] == 2'b00)) || (phase == PW'(PHASES - 1));

    always_ff @(posedge clk) begin
        if (rst || load) begin
            phase <= PW'(INIT);
            idx   <= GW'(INIT_IDX);
        end else if (advance) begin
            if (phase == PW'(PHASES - 1)) begin
                phase <= '0;
                idx   <= '0;
            end else begin
                phase <= phase + 1'b1;
                idx   <= (idx == GW'(GROUP - 1)) ? '0 : idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/syt_offset_acc.sv
module syt_offset_acc
    import syt_pkg::*;
#(
    parameter int W     = OFF_W,
    parameter int TICKS = TICKS_PER_CYC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step_en,
    input  logic [W-1:0] inc,
    output logic [W-1:0] off_next,
    output logic         applied
);
    logic [W-1:0] off_q;

    assign applied  = off_q < W'(TICKS);
    assign off_next = applied ? off_q + inc : off_q - W'(TICKS);

    always_ff @(posedge clk) begin
        if (rst || load)
            off_q <= W'(TICKS);
        else if (step_en)
            off_q <= off_next;
    end
endmodule

// File: rtl/syt_stamp_fmt.sv
module syt_stamp_fmt
    import syt_pkg::*;
#(
    parameter int W     = OFF_W,
    parameter int TICKS = TICKS_PER_CYC,
    parameter int MAX_Q = 6,
    parameter int AHEAD = QUEUE_AHEAD,
    parameter int WRAP  = CYC_WRAP
) (
    input  logic [W-1:0]  off_new,
    input  logic [W-1:0]  delay,
    input  logic [15:0]   cycle_in,
    output logic [15:0]   syt,
    output logic          none
);
    localparam int CW = $clog2(WRAP + 8192 + AHEAD);
    localparam int QW = $clog2(MAX_Q + 1);

    logic [CW-1:0] cyc_full, cyc_adj, cyc_sum;
    logic [W-1:0]  rem_s [0:MAX_Q];
    logic [QW-1:0] q_s   [0:MAX_Q];

    assign cyc_full = CW'(cycle_in[15:13]) * CW'(CYCS_PER_SEC)
                    + CW'(cycle_in[12:0]) + CW'(AHEAD);
    assign cyc_adj  = (cyc_full >= CW'(WRAP)) ? cyc_full - CW'(WRAP) : cyc_full;

    assign rem_s[0] = off_new + delay;
    assign q_s[0]   = '0;

    for (genvar g = 0; g < MAX_Q; g++) begin : g_sub
        assign rem_s[g+1] = (rem_s[g] >= W'(TICKS)) ? rem_s[g] - W'(TICKS) : rem_s[g];
        assign q_s[g+1]   = q_s[g] + ((rem_s[g] >= W'(TICKS)) ? QW'(1) : QW'(0));
    end

    assign cyc_sum = cyc_adj + CW'(q_s[MAX_Q]);
    assign none    = off_new >= W'(TICKS);
    assign syt     = none ? 16'hFFFF : {cyc_sum[3:0], rem_s[MAX_Q][11:0]};
endmodule

// File: rtl/syt_gen.sv
module syt_gen
    import syt_pkg::*;
#(
    parameter int W     = OFF_W,
    parameter int TICKS = TICKS_PER_CYC,
    parameter int AHEAD = QUEUE_AHEAD
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        cyc_strobe,
    input  logic [15:0] cycle_in,
    input  logic [2:0]  rate,
    input  logic        blocking,
    output logic [15:0] syt_out,
    output logic        syt_none,
    output logic        syt_valid
);
    rate_cfg_t    cfg;
    logic         step_en, applied, extra;
    logic [W-1:0] inc, off_next;
    logic [15:0]  syt_c;
    logic         none_c;

    assign cfg     = rate_cfg(rate_e'(rate), blocking);
    assign step_en = cyc_strobe && !start;
    assign inc     = cfg.frac ? W'(FRAC_STEP) + W'(extra) : cfg.step;

    syt_phase_seq u_phase (
        .clk     (clk),
        .rst     (rst),
        .load    (start),
        .advance (step_en && applied && cfg.frac),
        .extra   (extra)
    );

    syt_offset_acc #(.W(W), .TICKS(TICKS)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .step_en  (step_en),
        .inc      (inc),
        .off_next (off_next),
        .applied  (applied)
    );

    syt_stamp_fmt #(.W(W), .TICKS(TICKS), .AHEAD(AHEAD)) u_fmt (
        .off_new  (off_next),
        .delay    (cfg.delay),
        .cycle_in (cycle_in),
        .syt      (syt_c),
        .none     (none_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            syt_out   <= 16'hFFFF;
            syt_none  <= 1'b1;
            syt_valid <= 1'b0;
        end else begin
            syt_valid <= step_en;
            if (step_en) begin
                syt_out  <= syt_c;
                syt_none <= none_c;
            end
        end
    end
endmodule

// File: rtl/syt_gen_chk.sv
module syt_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        cyc_strobe,
    input logic [15:0] syt_out,
    input logic        syt_none,
    input logic        syt_valid
);
    // R2
    none_code_chk: assert property (@(posedge clk) disable iff (rst)
        syt_none |-> syt_out == 16'hFFFF);

    // R7
    tick_field_chk: assert property (@(posedge clk) disable iff (rst)
        !syt_none |-> syt_out[11:0] < 12'd3072);

    // R9
    valid_src_chk: assert property (@(posedge clk) disable iff (rst)
        syt_valid |-> $past(cyc_strobe));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cyc_strobe |=> ($stable(syt_out) && $stable(syt_none) && !syt_valid));

    // R10
    start_wins_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> !syt_valid);
endmodule

bind syt_gen syt_gen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .cyc_strobe (cyc_strobe),
    .syt_out    (syt_out),
    .syt_none   (syt_none),
    .syt_valid  (syt_valid)
);

// File: tb/sim_syt_gen.sv
module sim_syt_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        cyc_strobe = 1'b0;
    logic [15:0] cycle_in = '0;
    logic [2:0]  rate = 3'd2;
    logic        blocking = 1'b0;
    logic [15:0] syt_out;
    logic        syt_none;
    logic        syt_valid;

    int total = 0;
    int bad   = 0;
    int m_off;
    int m_ph;

    always #5 clk = ~clk;

    syt_gen u0 (
        .clk(clk), .rst(rst), .start(start), .cyc_strobe(cyc_strobe),
        .cycle_in(cycle_in), .rate(rate), .blocking(blocking),
        .syt_out(syt_out), .syt_none(syt_none), .syt_valid(syt_valid)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int delay_of(input int r, input logic blk);
        if (!blk) return 8704;
        if (r == 0) return 14848;
        if (r == 1 || r == 3 || r == 5) return 13162;
        return 12800;
    endfunction

    task automatic do_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        m_off = 3072;
        m_ph  = 67;
    endtask

    // strobe one cycle, then compare against the reference from the requirements
    task automatic strobe_cmp(input string req, input logic [15:0] cyc);
        int inc, d, c, k, exp;
        logic frac;
        @(negedge clk);
        cyc_strobe = 1'b1;
        cycle_in   = cyc;
        @(negedge clk);
        cyc_strobe = 1'b0;
        frac = (rate == 1 || rate == 3 || rate == 5);
        if (m_off < 3072) begin
            if (frac) begin
                k   = m_ph % 13;
                inc = 1386 + (((k != 0 && k % 4 == 0) || m_ph == 146) ? 1 : 0);
                m_ph = (m_ph + 1) % 147;
            end else begin
                inc = (rate == 0) ? 3072 : 1024;
            end
            m_off += inc;
        end else begin
            m_off -= 3072;
        end
        if (m_off < 3072) begin
            d   = m_off + delay_of(rate, blocking);
            c   = (int'(cyc[15:13]) * 8000 + int'(cyc[12:0]) + 48) % 64000;
            exp = (((c + d / 3072) * 4096) + d % 3072) % 65536;
            check({req, " stamp"}, syt_out, exp);
            check({req, " none"}, syt_none, 0);
        end else begin
            check({req, " nocode"}, syt_out, 16'hFFFF);
            check({req, " none"}, syt_none, 1);
        end
        check({req, " valid"}, syt_valid, 1);
    endtask

    task automatic t_reset();
        check("R9 reset valid", syt_valid, 0);
        check("R9 reset code", syt_out, 16'hFFFF);
        check("R9 reset none", syt_none, 1);
    endtask

    // hand-computed 48 kHz values
    task automatic t_first_stamp();
        rate = 3'd2; blocking = 1'b0;
        do_start();
        strobe_cmp("R1", 16'd0);
        check("R1 R5 R7 hand first", syt_out, 16'h2A00);
        strobe_cmp("R3", 16'd1);
        check("R3 R7 hand second", syt_out, 16'h4200);
    endtask

    task automatic t_wrap();
        rate = 3'd2; blocking = 1'b0;
        do_start();
        strobe_cmp("R8", {3'd7, 13'd7999});
        check("R8 hand wrap", syt_out, 16'h1A00);
    endtask

    task automatic t_32k_alt();
        rate = 3'd0; blocking = 1'b0;
        do_start();
        for (int i = 0; i < 6; i++) begin
            strobe_cmp("R2 R3 32k", 16'(i * 3));
            check("R2 alternate", syt_none, i % 2);
        end
    endtask

    task automatic t_frac(input logic [2:0] r, input logic blk, input int n);
        rate = r; blocking = blk;
        do_start();
        for (int i = 0; i < n; i++)
            strobe_cmp(blk ? "R4 R6 frac" : "R4 R5 frac", 16'(i * 37));
    endtask

    task automatic t_blocking_all();
        for (int r = 0; r < 8; r++) begin
            rate = 3'(r); blocking = 1'b1;
            do_start();
            for (int i = 0; i < 12; i++)
                strobe_cmp("R6 blocking", 16'(8000 * 3 + i * 101));
        end
    endtask

    task automatic t_hold();
        logic [15:0] held;
        rate = 3'd4; blocking = 1'b0;
        do_start();
        strobe_cmp("R9", 16'd500);
        held = syt_out;
        cycle_in = 16'd9;
        repeat (5) @(negedge clk);
        check("R9 hold code", syt_out, held);
        check("R9 hold valid", syt_valid, 0);
    endtask

    task automatic t_start_tick();
        rate = 3'd2; blocking = 1'b0;
        do_start();
        strobe_cmp("R10 pre", 16'd3);
        @(negedge clk);
        start = 1'b1; cyc_strobe = 1'b1; cycle_in = 16'd0;
        @(negedge clk);
        start = 1'b0; cyc_strobe = 1'b0;
        m_off = 3072; m_ph = 67;
        check("R10 no output", syt_valid, 0);
        strobe_cmp("R10 rearmed", 16'd0);
        check("R10 R1 first after", syt_out, 16'h2A00);
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_first_stamp();
        t_wrap();
        t_32k_alt();
        t_frac(3'd1, 1'b0, 320);
        t_frac(3'd3, 1'b0, 160);
        t_frac(3'd5, 1'b1, 160);
        t_blocking_all();
        t_hold();
        t_start_tick();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule